// File: doc/BRIEF.md
# Per-CPU Inter-Processor Doorbell

This unit gives every CPU of a cluster two doorbell interrupts, "other" and "self", kept in a separate bank for each CPU. All register accesses arrive on one access port and carry the index of the requesting CPU. Each access reaches only that CPU's bank. The exception is the send register, whose destination bits can ring the "other" doorbell of any CPU. For each CPU the unit drives two request lines, one per doorbell, into the interrupt controller's priority logic.

A CPU finds out which doorbell is active by reading the event register. The word it gets back has the same layout as a hardware-interrupt event: an 8-bit type in bits 23:16 and a 16-bit number in bits 15:0. Reading an event masks the doorbell it reports. The handler then acknowledges the doorbell and unmasks it again.

Each doorbell of each CPU is a small four-state machine. The state is the pair (ringing, open):
- QUIET_MASKED: not ringing, masked.
- QUIET_OPEN: not ringing, unmasked.
- RING_MASKED: ringing, masked.
- RING_OPEN: ringing, unmasked.

The transitions are:
- **ring**: QUIET_x goes to RING_x.
- **ack**: RING_x goes to QUIET_x.
- **mask**: x_OPEN goes to x_MASKED.
- **unmask**: x_MASKED goes to x_OPEN.
- **deliver**: RING_OPEN goes to RING_MASKED, taken on an event read.

Reset puts every machine in QUIET_MASKED.

Register selects on `acc_reg` are:
- 0: who-am-I.
- 1: event.
- 2: send.
- 3: acknowledge.
- 4: mask-set.
- 5: mask-clear.

Top module: `ipi_doorbell`

## Requirements
- R1: After reset, every doorbell is not ringing and is masked. Both request vectors are 0, and an event read returns 0.
- R2: A send write (select 2) with data bit n set, for n below NUM_CPU, rings the "other" doorbell of CPU n, whichever CPU writes.
- R3: A send write with data bit 31 set rings the "self" doorbell of the writing CPU only.
- R4: An acknowledge write (select 3) clears, in the writer's bank only, the "other" doorbell when data bit 0 is 1 and the "self" doorbell when data bit 31 is 1.
- R5: A mask-set write (select 4) masks, and a mask-clear write (select 5) unmasks, the writer's "other" doorbell (bit 0) and "self" doorbell (bit 31). `ipi_req_other[c]` and `ipi_req_self[c]` are high exactly while that doorbell is ringing and unmasked.
- R6: An event read (select 1) returns 32'h0004_0001 when the reader's "other" request is high. Otherwise it returns 32'h0004_0002 when its "self" request is high, and 0 when neither is high. Read data appears on `rd_data` with `rd_valid` in the cycle after the read.
- R7: The doorbell reported by an event read becomes masked and stays ringing. The other doorbell is unchanged.
- R8: While `hw_evt_pend[c]` is high, an event read by CPU c returns 0 and changes no doorbell.
- R9: A who-am-I read (select 0) returns the requesting CPU index.
- R10: Writes to selects 0, 1, 6 and 7 change no doorbell. Reads of any select other than 0 and 1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_cpu | input | CPU_W | Index of the requesting CPU |
| acc_reg | input | 3 | Register select |
| acc_wdata | input | 32 | Write data |
| hw_evt_pend | input | NUM_CPU | Hardware interrupt event waiting for CPU c (takes priority) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| ipi_req_other | output | NUM_CPU | Request line of each CPU's "other" doorbell |
| ipi_req_self | output | NUM_CPU | Request line of each CPU's "self" doorbell |

## Verification
The bench keeps a behavioural model with a ringing flag and a mask flag per doorbell. It compares both request vectors, and any read data, with that model after every access.

Directed sequences cover four distinctions:
- Sends to several CPUs at once separate the destination bits from the writer's own bank.
- Ringing both doorbells on one CPU separates the "other" > "self" order.
- Acknowledging from a different CPU separates per-CPU banking.
- Raising the hardware-pending input separates "blocked" from "delivered".

A long run of random accesses then mixes all selects, so that transitions meet in every state order.

// File: rtl/ipi_doorbell_pkg.sv
package ipi_doorbell_pkg;

    typedef enum logic [2:0] {
        SEL_WHOAMI = 3'd0,
        SEL_EVENT  = 3'd1,
        SEL_SEND   = 3'd2,
        SEL_ACK    = 3'd3,
        SEL_MSET   = 3'd4,
        SEL_MCLR   = 3'd5,
        SEL_RSV6   = 3'd6,
        SEL_RSV7   = 3'd7
    } reg_sel_e;

    // bit 1 = ringing, bit 0 = open (unmasked)
    typedef enum logic [1:0] {
        QUIET_MASKED = 2'b00,
        QUIET_OPEN   = 2'b01,
        RING_MASKED  = 2'b10,
        RING_OPEN    = 2'b11
    } slot_state_e;

    localparam int          DATA_W      = 32;
    localparam int          BIT_OTHER   = 0;
    localparam int          BIT_SELF    = 31;
    localparam logic [7:0]  EVT_TYPE_DB = 8'd4;
    localparam logic [15:0] EVT_NUM_OTH = 16'd1;
    localparam logic [15:0] EVT_NUM_SLF = 16'd2;

endpackage

// File: rtl/ipi_slot.sv
module ipi_slot
    import ipi_doorbell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_pend,
    input  logic clr_pend,
    input  logic set_mask,
    input  logic clr_mask,
    input  logic deliver,
    output logic pending,
    output logic masked,
    output logic req
);

    slot_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            QUIET_MASKED: begin
                if (set_pend)      state_d = RING_MASKED;
                else if (clr_mask) state_d = QUIET_OPEN;
            end
            QUIET_OPEN: begin
                if (set_pend)      state_d = RING_OPEN;
                else if (set_mask) state_d = QUIET_MASKED;
            end
            RING_MASKED: begin
                if (clr_pend)      state_d = QUIET_MASKED;
                else if (clr_mask) state_d = RING_OPEN;
            end
            RING_OPEN: begin
                if (clr_pend)                 state_d = QUIET_OPEN;
                else if (set_mask || deliver) state_d = RING_MASKED;
            end
            default: state_d = QUIET_MASKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= QUIET_MASKED;
        else        state_q <= state_d;
    end

    always_comb begin
        pending = 1'b0;
        masked  = 1'b1;
        unique case (state_q)
            QUIET_MASKED: begin pending = 1'b0; masked = 1'b1; end
            QUIET_OPEN:   begin pending = 1'b0; masked = 1'b0; end
            RING_MASKED:  begin pending = 1'b1; masked = 1'b1; end
            RING_OPEN:    begin pending = 1'b1; masked = 1'b0; end
            default:      begin pending = 1'b0; masked = 1'b1; end
        endcase
        req = pending && !masked;
    end

    a_r7_deliver_masks: assert property (@(posedge clk) disable iff (!rst_n)
        deliver |=> (masked && pending));
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pend |=> !pending);
    a_r2_send_rings: assert property (@(posedge clk) disable iff (!rst_n)
        set_pend |=> pending);
    a_r5_unmask_opens: assert property (@(posedge clk) disable iff (!rst_n)
        clr_mask |=> !masked);

endmodule

// File: rtl/ipi_evt_sel.sv
module ipi_evt_sel
    import ipi_doorbell_pkg::*;
(
    input  logic              hw_busy,
    input  logic              oth_req,
    input  logic              slf_req,
    output logic              take_oth,
    output logic              take_slf,
    output logic [DATA_W-1:0] evt_word
);

    always_comb begin
        take_oth = 1'b0;
        take_slf = 1'b0;
        evt_word = '0;
        if (!hw_busy) begin
            if (oth_req) begin
                take_oth = 1'b1;
                evt_word = {8'h00, EVT_TYPE_DB, EVT_NUM_OTH};
            end else if (slf_req) begin
                take_slf = 1'b1;
                evt_word = {8'h00, EVT_TYPE_DB, EVT_NUM_SLF};
            end
        end
    end

    a_r6_one_pick: assert final ($onehot0({take_oth, take_slf}));

endmodule

// File: rtl/ipi_doorbell.sv
module ipi_doorbell
    import ipi_doorbell_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [CPU_W-1:0]  acc_cpu,
    input  logic [2:0]        acc_reg,
    input  logic [31:0]       acc_wdata,
    input  logic [NUM_CPU-1:0] hw_evt_pend,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic [NUM_CPU-1:0] ipi_req_other,
    output logic [NUM_CPU-1:0] ipi_req_self
);

    localparam int SLOTS = 1 << CPU_W;

    reg_sel_e sel;
    logic     wr, rd;
    logic     cpu_ok;
    logic [SLOTS-1:0] req_oth_pad, req_slf_pad, hw_pad;
    logic [NUM_CPU-1:0] dlv_oth, dlv_slf;
    logic     take_oth, take_slf;
    logic [DATA_W-1:0] evt_word;

    assign sel    = reg_sel_e'(acc_reg);
    assign wr     = acc_valid && acc_write;
    assign rd     = acc_valid && !acc_write;
    assign cpu_ok = (int'(acc_cpu) < NUM_CPU);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic own;
        assign own = (int'(acc_cpu) == c);

        ipi_slot u_other (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_pend (wr && sel == SEL_SEND && acc_wdata[c]),
            .clr_pend (wr && sel == SEL_ACK  && own && acc_wdata[BIT_OTHER]),
            .set_mask (wr && sel == SEL_MSET && own && acc_wdata[BIT_OTHER]),
            .clr_mask (wr && sel == SEL_MCLR && own && acc_wdata[BIT_OTHER]),
            .deliver  (dlv_oth[c]),
            .pending  (),
            .masked   (),
            .req      (ipi_req_other[c])
        );

        ipi_slot u_self (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_pend (wr && sel == SEL_SEND && own && acc_wdata[BIT_SELF]),
            .clr_pend (wr && sel == SEL_ACK  && own && acc_wdata[BIT_SELF]),
            .set_mask (wr && sel == SEL_MSET && own && acc_wdata[BIT_SELF]),
            .clr_mask (wr && sel == SEL_MCLR && own && acc_wdata[BIT_SELF]),
            .deliver  (dlv_slf[c]),
            .pending  (),
            .masked   (),
            .req      (ipi_req_self[c])
        );

        assign dlv_oth[c] = rd && sel == SEL_EVENT && own && take_oth;
        assign dlv_slf[c] = rd && sel == SEL_EVENT && own && take_slf;
    end

    always_comb begin
        req_oth_pad = '0;
        req_slf_pad = '0;
        hw_pad      = '0;
        req_oth_pad[NUM_CPU-1:0] = ipi_req_other;
        req_slf_pad[NUM_CPU-1:0] = ipi_req_self;
        hw_pad[NUM_CPU-1:0]      = hw_evt_pend;
    end

    ipi_evt_sel u_sel (
        .hw_busy  (hw_pad[acc_cpu] || !cpu_ok),
        .oth_req  (req_oth_pad[acc_cpu]),
        .slf_req  (req_slf_pad[acc_cpu]),
        .take_oth (take_oth),
        .take_slf (take_slf),
        .evt_word (evt_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd;
            if (rd) begin
                unique case (sel)
                    SEL_WHOAMI: rd_data <= DATA_W'(acc_cpu);
                    SEL_EVENT:  rd_data <= evt_word;
                    default:    rd_data <= '0;
                endcase
            end
        end
    end

    a_r6_single_delivery: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dlv_oth, dlv_slf}));
    a_r9_whoami: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_WHOAMI) |=> (rd_valid && rd_data == 32'($past(acc_cpu))));
    a_r8_hw_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_EVENT && cpu_ok && hw_pad[acc_cpu]) |=>
            (rd_data == '0 && $stable(ipi_req_other) && $stable(ipi_req_self)));
    a_r10_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel != SEL_WHOAMI && sel != SEL_EVENT) |=> (rd_data == '0));
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> (ipi_req_other == '0 && ipi_req_self == '0));

endmodule

// File: tb/tb_ipi_doorbell.sv
module tb_ipi_doorbell;

    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_cpu = '0;
    logic [2:0]  acc_reg = '0;
    logic [31:0] acc_wdata = '0;
    logic [NC-1:0] hw_evt_pend = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [NC-1:0] ipi_req_other, ipi_req_self;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model
    bit p_oth[NC], p_slf[NC], m_oth[NC], m_slf[NC];

    always #2 clk = ~clk;

    ipi_doorbell #(.NUM_CPU(NC)) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_cpu(acc_cpu), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
        .hw_evt_pend(hw_evt_pend), .rd_valid(rd_valid), .rd_data(rd_data),
        .ipi_req_other(ipi_req_other), .ipi_req_self(ipi_req_self)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [NC-1:0] exp_oth();
        logic [NC-1:0] v;
        for (int c = 0; c < NC; c++) v[c] = p_oth[c] && !m_oth[c];
        return v;
    endfunction

    function automatic logic [NC-1:0] exp_slf();
        logic [NC-1:0] v;
        for (int c = 0; c < NC; c++) v[c] = p_slf[c] && !m_slf[c];
        return v;
    endfunction

    task automatic acc(input bit w, input int cpu, input int r, input logic [31:0] d,
                       input string tag);
        logic [31:0] exp_rd;
        exp_rd = '0;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_cpu = 2'(cpu); acc_reg = 3'(r); acc_wdata = d;
        if (w) begin
            case (r)
                2: begin
                    for (int c = 0; c < NC; c++) if (d[c]) p_oth[c] = 1;
                    if (d[31]) p_slf[cpu] = 1;
                end
                3: begin if (d[0]) p_oth[cpu] = 0; if (d[31]) p_slf[cpu] = 0; end
                4: begin if (d[0]) m_oth[cpu] = 1; if (d[31]) m_slf[cpu] = 1; end
                5: begin if (d[0]) m_oth[cpu] = 0; if (d[31]) m_slf[cpu] = 0; end
                default: ;
            endcase
        end else if (r == 0) begin
            exp_rd = cpu;
        end else if (r == 1 && !hw_evt_pend[cpu]) begin
            if (p_oth[cpu] && !m_oth[cpu]) begin
                exp_rd = 32'h0004_0001; m_oth[cpu] = 1;
            end else if (p_slf[cpu] && !m_slf[cpu]) begin
                exp_rd = 32'h0004_0002; m_slf[cpu] = 1;
            end
        end
        @(posedge clk);
        #1;
        if (!w) begin
            chk({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
            chk({tag, " rd_data"}, rd_data, exp_rd);
        end
        chk({tag, " req_other"}, 32'(ipi_req_other), 32'(exp_oth()));
        chk({tag, " req_self"}, 32'(ipi_req_self), 32'(exp_slf()));
        acc_valid = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            p_oth[c] = 0; p_slf[c] = 0; m_oth[c] = 1; m_slf[c] = 1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R1 reset req_other", 32'(ipi_req_other), 0);
        chk("R1 reset req_self", 32'(ipi_req_self), 0);
        for (int c = 0; c < NC; c++) acc(0, c, 1, 0, "R1 event after reset");
        for (int c = 0; c < NC; c++) acc(0, c, 0, 0, "R9 whoami");
        // R2 ringing while masked: no request
        acc(1, 0, 2, 32'h6, "R2 send masked");
        for (int c = 0; c < NC; c++) acc(1, c, 5, 32'h8000_0001, "R5 unmask all");
        acc(0, 1, 1, 0, "R6 R7 deliver other cpu1");
        acc(0, 1, 1, 0, "R7 masked after deliver");
        acc(1, 1, 5, 32'h1, "R7 still ringing after unmask");
        acc(1, 1, 3, 32'h1, "R4 ack other cpu1");
        acc(1, 3, 2, 32'h8000_0008, "R3 send self and other cpu3");
        acc(0, 3, 1, 0, "R6 other before self");
        acc(0, 3, 1, 0, "R6 self second");
        acc(0, 3, 1, 0, "R6 none left");
        acc(1, 3, 3, 32'h8000_0001, "R4 ack both cpu3");
        hw_evt_pend = 4'b0100;
        acc(0, 2, 1, 0, "R8 hw pending blocks");
        hw_evt_pend = 4'b0000;
        acc(1, 0, 3, 32'h8000_0001, "R4 ack in other bank");
        acc(0, 2, 1, 0, "R8 delivered after hw clears");
        acc(1, 2, 5, 32'h1, "R5 unmask cpu2");
        acc(1, 2, 0, 32'hFFFF_FFFF, "R10 write whoami ignored");
        acc(1, 2, 1, 32'hFFFF_FFFF, "R10 write event ignored");
        acc(1, 2, 6, 32'hFFFF_FFFF, "R10 write rsv ignored");
        acc(0, 2, 2, 0, "R10 read send zero");
        acc(0, 2, 5, 0, "R10 read mclr zero");
        acc(1, 2, 4, 32'h8000_0000, "R5 mask self cpu2");
        acc(1, 2, 2, 32'h8000_0000, "R3 self ring masked");
        acc(1, 2, 5, 32'h8000_0000, "R5 unmask self cpu2");
        for (int i = 0; i < 3000; i++) begin
            int r, c;
            logic [31:0] d;
            r = $urandom_range(0, 7);
            c = $urandom_range(0, NC - 1);
            d = {$urandom_range(0, 1) == 1, 26'h0, 5'($urandom_range(0, 31))};
            hw_evt_pend = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            acc($urandom_range(0, 1) == 1, c, r, d, "R6 random mix");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule